// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Fault Latch

This block is the digital over-current handler of one channel of a switching regulator controller. It runs on the system clock and is told where each switching cycle begins by a single-cycle strobe. An external comparator reports, as a digital flag, whether the sensed current is above the programmed limit. When the flag is found high at a cycle start, the handler blocks the high-side switch for that cycle and for eight further cycles. It then opens an eight-cycle observation window. A second limit hit in that window shuts the channel down for good. A clean window returns the handler to rest.

A shut-down channel keeps the high-side switch blocked and pulls its power-good indication low. Only dropping the channel enable or applying a full reset releases it. The skip and observation lengths are parameters, and the cycle counter width is derived from them. The defaults are eight cycles each, which gives a 5-bit counter.

Top module: `ocp_pulse_skip`

## Requirements
- R1: After reset, `hs_block`, `oc_fault` and `pgood_pull` are all low.
- R2: When the handler is at rest and `ilim_hit` is high on a clock edge where `cyc_stb` and `en` are high, `hs_block` goes high on that edge. That starting cycle is cycle 0.
- R3: After a detection, `hs_block` stays high through cycles 0 to 8 and falls on the ninth strobe that follows the detection strobe, provided no fault is latched.
- R4: Limit hits sampled on the strobes of cycles 1 to 8 are ignored. They neither lengthen the blocked period nor latch a fault.
- R5: A limit hit sampled on the strobe that starts any of cycles 9 to 16 sets `oc_fault` and keeps `hs_block` high. Both then stay high while `en` stays high.
- R6: If no limit hit is sampled in cycles 9 to 16, the handler returns to rest. A hit on the strobe that starts cycle 17 or any later cycle starts a fresh nine-cycle block and does not latch.
- R7: While `en` is low, the handler is held at rest: `hs_block` and `oc_fault` are low, and `ilim_hit` is ignored. This clears a latched fault and abandons a skip in progress.
- R8: `ilim_hit` is sampled only on edges where `cyc_stb` is high. On all other edges it has no effect, and the outputs hold their values between strobes.
- R9: `pgood_pull` is high exactly when `oc_fault` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Channel enable; low holds the handler at rest and clears a latched fault |
| cyc_stb | input | 1 | Single-clock strobe marking the start of a switching cycle |
| ilim_hit | input | 1 | Current-limit comparator flag |
| hs_block | output | 1 | High-side drive inhibit |
| oc_fault | output | 1 | Over-current fault latch, channel shut down |
| pgood_pull | output | 1 | Pulls the channel's power-good indication low |

## Verification
The bench places a second limit hit at each strobe from 1 to 20 after a first detection. It sweeps across the skip/observe boundary at cycle 9 and the observe/rest boundary at cycle 17. An off-by-one window would latch on cycle 8 or 17, or miss cycle 9 or 16. A handler that restarts its count would hold the block past cycle 8. The limit flag is also held high between strobes, so a design that samples on every edge would latch at once. Each sweep ends by dropping enable, and a separate case drops it partway through a skip. A design whose latch survives the toggle, or whose skip resumes afterwards, shows a stuck `hs_block`.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OC_REST  = 2'd0,
    OC_SKIP  = 2'd1,
    OC_WATCH = 2'd2,
    OC_LOCK  = 2'd3
  } oc_state_e;
endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/ocp_cycle_cnt.sv
module ocp_cycle_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr | inc) cnt <= cnt_d;
  end
endmodule

// File: rtl/ocp_ctrl_fsm.sv
module ocp_ctrl_fsm
  import ocp_pkg::*;
#(
  parameter int SKIP_CYC = 8,
  parameter int LAST_CYC = 16,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             stb,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt,
  output oc_state_e        state,
  output logic             cnt_clr,
  output logic             cnt_inc
);
  localparam logic [CNT_W-1:0] SKIP_END = CNT_W'(SKIP_CYC);
  localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(LAST_CYC);

  oc_state_e state_d;

  always_comb begin
    state_d = state;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (!en) begin
      state_d = OC_REST;
      cnt_clr = 1'b1;
    end else if (stb) begin
      unique case (state)
        OC_REST: begin
          if (hit) begin
            state_d = OC_SKIP;
            cnt_clr = 1'b1;
          end
        end
        OC_SKIP: begin
          cnt_inc = 1'b1;
          if (cnt == SKIP_END) state_d = hit ? OC_LOCK : OC_WATCH;
        end
        OC_WATCH: begin
          if (cnt == WIN_END) begin
            state_d = hit ? OC_SKIP : OC_REST;
            cnt_clr = 1'b1;
          end else if (hit) begin
            state_d = OC_LOCK;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        OC_LOCK: state_d = OC_LOCK;
        default: state_d = OC_REST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OC_REST;
    else        state <= state_d;
  end
endmodule

// File: rtl/ocp_pulse_skip.sv
module ocp_pulse_skip
  import ocp_pkg::*;
#(
  parameter int SKIP_CYC  = 8,
  parameter int WATCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_stb,
  input  logic ilim_hit,
  output logic hs_block,
  output logic oc_fault,
  output logic pgood_pull
);
  localparam int LAST_CYC = SKIP_CYC + WATCH_CYC;
  localparam int CNT_W    = $clog2(LAST_CYC + 1);

  logic             rst_int_n;
  logic             cnt_clr;
  logic             cnt_inc;
  logic [CNT_W-1:0] cnt;
  oc_state_e        state;

  ocp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ocp_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  ocp_ctrl_fsm #(
    .SKIP_CYC (SKIP_CYC),
    .LAST_CYC (LAST_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (en),
    .stb     (cyc_stb),
    .hit     (ilim_hit),
    .cnt     (cnt),
    .state   (state),
    .cnt_clr (cnt_clr),
    .cnt_inc (cnt_inc)
  );

  assign hs_block   = (state == OC_SKIP) || (state == OC_LOCK);
  assign oc_fault   = (state == OC_LOCK);
  assign pgood_pull = oc_fault;
endmodule

// File: rtl/ocp_pulse_skip_chk.sv
module ocp_pulse_skip_chk #(
  parameter int LAST_CYC = 16,
  parameter int CNT_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             cyc_stb,
  input logic             ilim_hit,
  input logic             hs_block,
  input logic             oc_fault,
  input logic             pgood_pull,
  input logic [CNT_W-1:0] cnt
);
  assert_block_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_block) |-> $past(cyc_stb && ilim_hit && en));

  assert_fault_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_fault) |-> $past(cyc_stb && ilim_hit && en));

  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fault && en) |=> oc_fault);

  assert_fault_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |-> (hs_block && pgood_pull));

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!oc_fault && !hs_block));

  assert_quiet_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cyc_stb) |=> ($stable(hs_block) && $stable(oc_fault)));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LAST_CYC));
endmodule

bind ocp_pulse_skip ocp_pulse_skip_chk #(
  .LAST_CYC (LAST_CYC),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .cyc_stb    (cyc_stb),
  .ilim_hit   (ilim_hit),
  .hs_block   (hs_block),
  .oc_fault   (oc_fault),
  .pgood_pull (pgood_pull),
  .cnt        (cnt)
);

// File: tb/ocp_pulse_skip_test.sv
module ocp_pulse_skip_test;
  logic clk;
  logic rst_n;
  logic en;
  logic cyc_stb;
  logic ilim_hit;
  logic hs_block;
  logic oc_fault;
  logic pgood_pull;

  int tests;
  int fails;
  int cycles;
  bit done;

  ocp_pulse_skip uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cyc_stb    (cyc_stb),
    .ilim_hit   (ilim_hit),
    .hs_block   (hs_block),
    .oc_fault   (oc_fault),
    .pgood_pull (pgood_pull)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic blk, input logic flt);
    tests++;
    if (hs_block !== blk || oc_fault !== flt || pgood_pull !== flt) begin
      fails++;
      $display("FAIL %s: actual blk=%b flt=%b pg=%b expected blk=%b flt=%b pg=%b",
               req, hs_block, oc_fault, pgood_pull, blk, flt, flt);
    end
  endtask

  // one cycle start, then a gap with the flag held high off-strobe (R8 noise)
  task automatic strobe(input logic hit);
    @(negedge clk);
    cyc_stb  = 1'b1;
    ilim_hit = hit;
    @(negedge clk);
    cyc_stb  = 1'b0;
    ilim_hit = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic toggle_en();
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; en = 1'b1; cyc_stb = 1'b0; ilim_hit = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 1'b0, 1'b0);

    // R8: flag high for many edges without a strobe
    ilim_hit = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 no strobe", 1'b0, 1'b0);

    // sweep: second hit at strobe k after detection (strobe 0)
    for (int k = 1; k <= 20; k++) begin
      strobe(1'b1);
      check("R2 detect", 1'b1, 1'b0);
      for (int j = 1; j <= 28; j++) begin
        logic eb, ef;
        strobe(j == k);
        ef = (k >= 9) && (k <= 16) && (j >= k);
        eb = ef || (j <= 8) || ((k >= 17) && (j >= k) && (j <= k + 8));
        if (ef)             check("R5 latch in window", eb, ef);
        else if (j <= 8)    check("R3/R4 skip window", eb, ef);
        else if (k >= 17)   check("R6 fresh after window", eb, ef);
        else                check("R3/R6 released", eb, ef);
      end
      toggle_en();
      check("R7 enable toggle clears", 1'b0, 1'b0);
      strobe(1'b0);
      check("R7 stays clear", 1'b0, 1'b0);
    end

    // R7: enable drop during skip abandons it; low enable ignores hits
    strobe(1'b1);
    strobe(1'b0);
    strobe(1'b0);
    check("R3 mid skip", 1'b1, 1'b0);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R7 abort skip", 1'b0, 1'b0);
    cyc_stb = 1'b1; ilim_hit = 1'b1;
    repeat (3) @(negedge clk);
    cyc_stb = 1'b0;
    check("R7 hit ignored while disabled", 1'b0, 1'b0);
    en = 1'b1;
    @(negedge clk);
    strobe(1'b0);
    check("R7 no resumed skip", 1'b0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule